// File: doc/BRIEF.md
# Erase-Count Wear Statistics Unit

This block keeps one erase counter for every erase block of a flash array, plus a running count of all erases. Each erase event names a block; the block's counter and the running total both advance by one. When a block counter or the running total wraps past its all-ones value, a sticky overflow flag for that counter is raised and stays set until reset.

On a start pulse the unit makes two sequential passes over the counter memory, reading one entry per cycle. The first pass finds the smallest count, the largest count and the sum of all counts. A restoring divider that produces one quotient bit per cycle then computes the truncated average and nine bin bounds. Each bound is the maximum times the bin number plus one, plus five, divided by ten. The tenth bound is the maximum itself. The second pass places every block in the lowest bin whose bound is not below its count. A bin whose lower edge lies above its bound is marked empty. The lower edge is zero for the first bin and one past the previous bound for the others.

All results sit in output registers that change only in the cycle of a one-cycle done pulse. Erase events that arrive while the unit is busy are dropped rather than queued. This includes the cycle of the start pulse and the counter-clearing sweep after reset.

Top module: `wear_stats_unit`

## Requirements
- R1: After reset the unit sweeps the counter memory to zero, one entry per cycle, with `busy` high; `done`, both overflow flags and `run_total` read 0 during and after reset.
- R2: An erase event accepted while idle (`busy` low, `start` low) adds one, modulo 2^CNT_W, to the addressed block's counter, and adds one, modulo 2^TOT_W, to `run_total` on the next edge. Back-to-back events, including repeated events to one block, are all counted.
- R3: When a block counter wraps from all-ones to zero, `blk_ovf` is set and stays set until reset.
- R4: When `run_total` wraps from all-ones to zero, `tot_ovf` is set and stays set until reset.
- R5: A start pulse while idle produces `out_min`, `out_max` and `out_sum` equal to the minimum, maximum and sum of all block counters.
- R6: `out_avg` equals `out_sum` divided by NUM_BLOCKS, rounded down.
- R7: Bin bound i, held in `out_bounds[i*CNT_W +: CNT_W]`, equals (max*(i+1)+5)/10 in integer arithmetic for i = 0..8; bound 9 equals max.
- R8: Bin count i, in `out_hist[i*(BLK_W+1) +: BLK_W+1]`, is the number of blocks whose lowest bin with bound >= count is i.
- R9: `out_empty[i]` is 1 exactly when the bin's lower edge is above its bound. The lower edge is 0 for i = 0 and bound[i-1]+1 otherwise.
- R10: Erase events presented while `busy` is high, or in the same cycle as an accepted `start`, change no counter and leave `run_total` unchanged.
- R11: `done` is a one-cycle pulse; all `out_*` results change only in the cycle `done` is high and otherwise hold.

Here BLK_W = clog2(NUM_BLOCKS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_valid | input | 1 | Erase event strobe |
| erase_block | input | BLK_W | Block number of the erase event |
| start | input | 1 | Begin a statistics computation |
| busy | output | 1 | Clearing or computing; events and start ignored |
| done | output | 1 | One-cycle pulse when results update |
| run_total | output | TOT_W | Running count of accepted erases |
| blk_ovf | output | 1 | Sticky: some block counter wrapped |
| tot_ovf | output | 1 | Sticky: running total wrapped |
| out_sum | output | CNT_W+BLK_W | Sum of block counters |
| out_min | output | CNT_W | Smallest block counter |
| out_max | output | CNT_W | Largest block counter |
| out_avg | output | CNT_W | Truncated average counter |
| out_bounds | output | 10*CNT_W | Bin upper bounds, bin 0 in the low bits |
| out_hist | output | 10*(BLK_W+1) | Blocks per bin, bin 0 in the low bits |
| out_empty | output | 10 | Per-bin empty-range flag |

## Verification
The assertions assume that `start` is raised only while `busy` is low and that `erase_block` is always below NUM_BLOCKS. NUM_BLOCKS must be a power of two so that every address is a real block. The bench drives every event and start pulse from tasks that first wait for `busy` to fall. The bench also picks block numbers only from the valid range. The one deliberate exception is a burst of events, and a second start pulse, during a computation; the bench uses it to check that the unit drops them.

// File: rtl/wear_pkg.sv
package wear_pkg;
  localparam int NUM_BINS  = 10;
  localparam int DIV_BINS  = NUM_BINS - 1;
  localparam int BIN_IDX_W = 4;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_PASS1,
    ST_AVG,
    ST_BOUND,
    ST_PASS2,
    ST_FIN
  } wear_state_e;
endpackage

// File: rtl/wear_cnt_ram.sv
module wear_cnt_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wear_seq_div.sv
module wear_seq_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted  = {rem_q[W-1:0], quo_q[W-1]};
  assign trial    = shifted - {1'b0, dvs_q};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[W]) begin
          rem_q <= trial;
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wear_hist_bins.sv
module wear_hist_bins #(
  parameter int CNT_W = 8,
  parameter int HC_W  = 6,
  parameter int NB    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  input  logic [CNT_W-1:0]   value,
  input  logic [NB*CNT_W-1:0] bounds,
  output logic [NB*HC_W-1:0] counts,
  output logic [NB-1:0]      empty
);
  logic [NB-1:0] hit;
  logic [NB:0]   taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NB; i++) begin : g_bin
    logic [CNT_W-1:0] bnd;
    logic [CNT_W:0]   lower;
    logic [HC_W-1:0]  cnt_q;

    assign bnd = bounds[i*CNT_W +: CNT_W];
    assign hit[i] = (value <= bnd);
    assign taken[i+1] = taken[i] | hit[i];

    if (i == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = {1'b0, bounds[(i-1)*CNT_W +: CNT_W]} + 1'b1;
    end
    assign empty[i] = (lower > {1'b0, bnd});

    always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (inc && hit[i] && !taken[i]) cnt_q <= cnt_q + 1'b1;
    end
    assign counts[i*HC_W +: HC_W] = cnt_q;
  end
endmodule

// File: rtl/wear_stats_unit.sv
module wear_stats_unit import wear_pkg::*; #(
  parameter int NUM_BLOCKS = 32,
  parameter int CNT_W      = 8,
  parameter int TOT_W      = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     erase_valid,
  input  logic [$clog2(NUM_BLOCKS)-1:0]            erase_block,
  input  logic                                     start,
  output logic                                     busy,
  output logic                                     done,
  output logic [TOT_W-1:0]                         run_total,
  output logic                                     blk_ovf,
  output logic                                     tot_ovf,
  output logic [CNT_W+$clog2(NUM_BLOCKS)-1:0]      out_sum,
  output logic [CNT_W-1:0]                         out_min,
  output logic [CNT_W-1:0]                         out_max,
  output logic [CNT_W-1:0]                         out_avg,
  output logic [NUM_BINS*CNT_W-1:0]                out_bounds,
  output logic [NUM_BINS*($clog2(NUM_BLOCKS)+1)-1:0] out_hist,
  output logic [NUM_BINS-1:0]                      out_empty
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int SUM_W = CNT_W + BLK_W;
  localparam int DIV_W = (BLK_W > 4) ? SUM_W : CNT_W + 4;
  localparam int HC_W  = BLK_W + 1;

  wear_state_e state_q;

  // event pipeline
  logic             accept;
  logic             s2_vld;
  logic [BLK_W-1:0] s2_addr;
  logic             fwd_vld;
  logic [BLK_W-1:0] fwd_addr;
  logic [CNT_W-1:0] fwd_data;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] nxt_cnt;

  // memory ports
  logic             mem_we;
  logic [BLK_W-1:0] mem_waddr;
  logic [CNT_W-1:0] mem_wdata;
  logic [BLK_W-1:0] mem_raddr;
  logic [CNT_W-1:0] rd_data;

  // scan and statistics
  logic [BLK_W-1:0] clr_idx_q;
  logic [BLK_W:0]   scan_idx_q;
  logic             scan_issue;
  logic             dv_q;
  logic             scan_end;
  logic [CNT_W-1:0] min_q;
  logic [CNT_W-1:0] max_q;
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] avg_q;
  logic [BIN_IDX_W-1:0] bin_idx_q;
  logic [CNT_W-1:0] bound_q [NUM_BINS];
  logic [NUM_BINS*CNT_W-1:0] bounds_flat;

  // divider and histogram
  logic             div_start_q;
  logic             div_done;
  logic [DIV_W-1:0] div_num;
  logic [DIV_W-1:0] div_den;
  logic [DIV_W-1:0] div_quo;
  logic             hist_clr_q;
  logic [NUM_BINS*HC_W-1:0] hist_counts;
  logic [NUM_BINS-1:0]      hist_empty;

  assign busy   = (state_q != ST_IDLE);
  assign accept = (state_q == ST_IDLE) && erase_valid && !start;

  assign cur_cnt = (fwd_vld && (fwd_addr == s2_addr)) ? fwd_data : rd_data;
  assign nxt_cnt = cur_cnt + 1'b1;

  always_comb begin
    if (state_q == ST_CLEAR) begin
      mem_we    = 1'b1;
      mem_waddr = clr_idx_q;
      mem_wdata = '0;
    end else begin
      mem_we    = s2_vld;
      mem_waddr = s2_addr;
      mem_wdata = nxt_cnt;
    end
  end

  assign scan_issue = ((state_q == ST_PASS1) || (state_q == ST_PASS2)) &&
                      (scan_idx_q < (BLK_W+1)'(NUM_BLOCKS));
  assign scan_end   = !scan_issue && !dv_q &&
                      (scan_idx_q == (BLK_W+1)'(NUM_BLOCKS));
  assign mem_raddr  = scan_issue ? scan_idx_q[BLK_W-1:0] : erase_block;

  wear_cnt_ram #(.DEPTH(NUM_BLOCKS), .AW(BLK_W), .DW(CNT_W)) i_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  // event read-modify-write with one-deep forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld    <= 1'b0;
      s2_addr   <= '0;
      fwd_vld   <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      run_total <= '0;
      blk_ovf   <= 1'b0;
      tot_ovf   <= 1'b0;
    end else begin
      s2_vld   <= accept;
      s2_addr  <= erase_block;
      fwd_vld  <= s2_vld;
      fwd_addr <= s2_addr;
      fwd_data <= nxt_cnt;
      if (s2_vld && (&cur_cnt)) blk_ovf <= 1'b1;
      if (accept) begin
        run_total <= run_total + 1'b1;
        if (&run_total) tot_ovf <= 1'b1;
      end
    end
  end

  assign div_num = (state_q == ST_AVG) ? DIV_W'(sum_q)
                 : DIV_W'(max_q) * (DIV_W'(bin_idx_q) + DIV_W'(1)) + DIV_W'(5);
  assign div_den = (state_q == ST_AVG) ? DIV_W'(NUM_BLOCKS) : DIV_W'(10);

  wear_seq_div #(.W(DIV_W)) i_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start_q),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (div_quo)
  );

  for (genvar i = 0; i < NUM_BINS; i++) begin : g_flat
    assign bounds_flat[i*CNT_W +: CNT_W] = bound_q[i];
  end

  wear_hist_bins #(.CNT_W(CNT_W), .HC_W(HC_W), .NB(NUM_BINS)) i_hist (
    .clk    (clk),
    .rst    (rst),
    .clr    (hist_clr_q),
    .inc    (dv_q && (state_q == ST_PASS2)),
    .value  (rd_data),
    .bounds (bounds_flat),
    .counts (hist_counts),
    .empty  (hist_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_CLEAR;
      clr_idx_q   <= '0;
      scan_idx_q  <= '0;
      dv_q        <= 1'b0;
      min_q       <= '1;
      max_q       <= '0;
      sum_q       <= '0;
      avg_q       <= '0;
      bin_idx_q   <= '0;
      div_start_q <= 1'b0;
      hist_clr_q  <= 1'b0;
      done        <= 1'b0;
      out_sum     <= '0;
      out_min     <= '0;
      out_max     <= '0;
      out_avg     <= '0;
      out_bounds  <= '0;
      out_hist    <= '0;
      out_empty   <= '0;
      for (int i = 0; i < NUM_BINS; i++) bound_q[i] <= '0;
    end else begin
      div_start_q <= 1'b0;
      hist_clr_q  <= 1'b0;
      done        <= 1'b0;
      dv_q        <= scan_issue;
      if (scan_issue) scan_idx_q <= scan_idx_q + 1'b1;
      case (state_q)
        ST_CLEAR: begin
          clr_idx_q <= clr_idx_q + 1'b1;
          if (clr_idx_q == BLK_W'(NUM_BLOCKS - 1)) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (start) begin
            min_q      <= '1;
            max_q      <= '0;
            sum_q      <= '0;
            scan_idx_q <= '0;
            hist_clr_q <= 1'b1;
            state_q    <= ST_PASS1;
          end
        end
        ST_PASS1: begin
          if (dv_q) begin
            if (rd_data < min_q) min_q <= rd_data;
            if (rd_data > max_q) max_q <= rd_data;
            sum_q <= sum_q + SUM_W'(rd_data);
          end
          if (scan_end) begin
            div_start_q <= 1'b1;
            state_q     <= ST_AVG;
          end
        end
        ST_AVG: begin
          if (div_done) begin
            avg_q       <= div_quo[CNT_W-1:0];
            bin_idx_q   <= '0;
            div_start_q <= 1'b1;
            state_q     <= ST_BOUND;
          end
        end
        ST_BOUND: begin
          if (div_done) begin
            bound_q[bin_idx_q] <= div_quo[CNT_W-1:0];
            if (bin_idx_q == BIN_IDX_W'(DIV_BINS - 1)) begin
              bound_q[NUM_BINS-1] <= max_q;
              scan_idx_q          <= '0;
              state_q             <= ST_PASS2;
            end else begin
              bin_idx_q   <= bin_idx_q + 1'b1;
              div_start_q <= 1'b1;
            end
          end
        end
        ST_PASS2: begin
          if (scan_end) state_q <= ST_FIN;
        end
        ST_FIN: begin
          out_sum    <= sum_q;
          out_min    <= min_q;
          out_max    <= max_q;
          out_avg    <= avg_q;
          out_bounds <= bounds_flat;
          out_hist   <= hist_counts;
          out_empty  <= hist_empty;
          done       <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wear_stats_chk.sv
module wear_stats_chk #(
  parameter int CNT_W = 8,
  parameter int TOT_W = 16,
  parameter int SUM_W = 13,
  parameter int NB    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             erase_valid,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [TOT_W-1:0] run_total,
  input logic             blk_ovf,
  input logic             tot_ovf,
  input logic [SUM_W-1:0] out_sum,
  input logic [CNT_W-1:0] out_min,
  input logic [CNT_W-1:0] out_max,
  input logic [NB-1:0]    out_empty
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_min) && $stable(out_max) && $stable(out_sum)));

  // R2
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && erase_valid && !start) |=> (run_total == TOT_W'($past(run_total) + 1'b1)));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(run_total));

  // R10
  start_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> $stable(run_total));

  // R3
  blk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    blk_ovf |=> blk_ovf);

  // R4
  tot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tot_ovf |=> tot_ovf);

  // R4
  tot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && erase_valid && !start && (&run_total)) |=> tot_ovf);

  // R5
  min_max_order_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_min <= out_max));

  // R9
  first_bin_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_empty[0]);
endmodule

bind wear_stats_unit wear_stats_chk #(
  .CNT_W (CNT_W),
  .TOT_W (TOT_W),
  .SUM_W (CNT_W + $clog2(NUM_BLOCKS)),
  .NB    (wear_pkg::NUM_BINS)
) i_wear_stats_chk (
  .clk         (clk),
  .rst         (rst),
  .erase_valid (erase_valid),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .run_total   (run_total),
  .blk_ovf     (blk_ovf),
  .tot_ovf     (tot_ovf),
  .out_sum     (out_sum),
  .out_min     (out_min),
  .out_max     (out_max),
  .out_empty   (out_empty)
);

// File: tb/test_wear_stats_unit.sv
module test_wear_stats_unit;
  localparam int NBLK = 8;
  localparam int CW   = 4;
  localparam int TW   = 7;
  localparam int BW   = 3;
  localparam int HW   = BW + 1;
  localparam int SW   = CW + BW;
  localparam int NBIN = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic erase_valid = 1'b0;
  logic [BW-1:0] erase_block = '0;
  logic start = 1'b0;
  logic busy, done, blk_ovf, tot_ovf;
  logic [TW-1:0] run_total;
  logic [SW-1:0] out_sum;
  logic [CW-1:0] out_min, out_max, out_avg;
  logic [NBIN*CW-1:0] out_bounds;
  logic [NBIN*HW-1:0] out_hist;
  logic [NBIN-1:0] out_empty;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int mdl_cnt [NBLK];
  int mdl_tot = 0;
  bit mdl_bov = 0;
  bit mdl_tov = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  wear_stats_unit #(.NUM_BLOCKS(NBLK), .CNT_W(CW), .TOT_W(TW)) i_wear_stats_unit (
    .clk(clk), .rst(rst), .erase_valid(erase_valid), .erase_block(erase_block),
    .start(start), .busy(busy), .done(done), .run_total(run_total),
    .blk_ovf(blk_ovf), .tot_ovf(tot_ovf), .out_sum(out_sum), .out_min(out_min),
    .out_max(out_max), .out_avg(out_avg), .out_bounds(out_bounds),
    .out_hist(out_hist), .out_empty(out_empty)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one event per call; back-to-back calls keep erase_valid high
  task automatic erase(input int b);
    erase_valid = 1'b1;
    erase_block = BW'(b);
    @(negedge clk);
    erase_valid = 1'b0;
    if (mdl_cnt[b] == (1 << CW) - 1) begin mdl_cnt[b] = 0; mdl_bov = 1; end
    else mdl_cnt[b]++;
    if (mdl_tot == (1 << TW) - 1) begin mdl_tot = 0; mdl_tov = 1; end
    else mdl_tot++;
  endtask

  task automatic check_counters(input string tag);
    @(negedge clk);
    @(negedge clk);
    chk("R2", {tag, " run_total"}, int'(run_total), mdl_tot);
    chk("R3", {tag, " blk_ovf"}, int'(blk_ovf), int'(mdl_bov));
    chk("R4", {tag, " tot_ovf"}, int'(tot_ovf), int'(mdl_tov));
  endtask

  function automatic int bound_of(input int mx, input int i);
    return (i < NBIN - 1) ? (mx * (i + 1) + 5) / 10 : mx;
  endfunction

  // start a computation; optionally push ignored events and a stray start while busy
  task automatic compute(input string tag, input bit noise);
    int mn, mx, sm, wait_cnt;
    int hist [NBIN];
    start = 1'b1;
    erase_valid = noise;
    erase_block = '0;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      for (int k = 0; k < 6; k++) begin
        start = (k == 3);
        @(negedge clk);
      end
      start = 1'b0;
      erase_valid = 1'b0;
    end
    wait_cnt = 0;
    while (done !== 1'b1 && wait_cnt < 5000) begin
      @(negedge clk);
      wait_cnt++;
    end
    mn = (1 << CW) - 1; mx = 0; sm = 0;
    for (int b = 0; b < NBLK; b++) begin
      if (mdl_cnt[b] < mn) mn = mdl_cnt[b];
      if (mdl_cnt[b] > mx) mx = mdl_cnt[b];
      sm += mdl_cnt[b];
    end
    for (int i = 0; i < NBIN; i++) hist[i] = 0;
    for (int b = 0; b < NBLK; b++) begin
      for (int i = 0; i < NBIN; i++) begin
        if (mdl_cnt[b] <= bound_of(mx, i)) begin hist[i]++; break; end
      end
    end
    chk("R11", {tag, " done seen"}, int'(done), 1);
    chk("R5", {tag, " min"}, int'(out_min), mn);
    chk("R5", {tag, " max"}, int'(out_max), mx);
    chk("R5", {tag, " sum"}, int'(out_sum), sm);
    chk("R6", {tag, " avg"}, int'(out_avg), sm / NBLK);
    for (int i = 0; i < NBIN; i++) begin
      int lo;
      lo = (i == 0) ? 0 : bound_of(mx, i - 1) + 1;
      chk("R7", $sformatf("%s bound%0d", tag, i), int'(out_bounds[i*CW +: CW]), bound_of(mx, i));
      chk("R8", $sformatf("%s hist%0d", tag, i), int'(out_hist[i*HW +: HW]), hist[i]);
      chk("R9", $sformatf("%s empty%0d", tag, i), int'(out_empty[i]), int'(lo > bound_of(mx, i)));
    end
    @(negedge clk);
    chk("R11", {tag, " done one cycle"}, int'(done), 0);
    chk("R10", {tag, " run_total after busy"}, int'(run_total), mdl_tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int w;
    logic [CW-1:0] held_max;
    logic [SW-1:0] held_sum;
    for (int b = 0; b < NBLK; b++) mdl_cnt[b] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 1);
    chk("R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy while clearing", int'(busy), 1);
    chk("R1", "run_total after reset", int'(run_total), 0);
    chk("R1", "blk_ovf after reset", int'(blk_ovf), 0);
    chk("R1", "tot_ovf after reset", int'(tot_ovf), 0);
    w = 0;
    while (busy && w < 100) begin @(negedge clk); w++; end
    chk("R1", "clear sweep length", w, NBLK - 1);

    // R1: all counters zero after the sweep
    compute("zero", 1'b0);

    // R2: ramp pattern, back-to-back
    for (int b = 0; b < NBLK; b++)
      for (int k = 0; k < b; k++) erase(b);
    check_counters("ramp");
    compute("ramp", 1'b0);

    // R2: same block repeatedly in consecutive cycles
    for (int k = 0; k < 5; k++) erase(2);
    erase(5); erase(2); erase(5);
    check_counters("repeat");
    compute("repeat", 1'b0);

    // R11: outputs hold across idle events
    held_max = out_max;
    held_sum = out_sum;
    erase(7); erase(7);
    repeat (4) @(negedge clk);
    chk("R11", "max held", int'(out_max), int'(held_max));
    chk("R11", "sum held", int'(out_sum), int'(held_sum));

    // R3: wrap block 3
    for (int k = 0; k < (1 << CW); k++) erase(3);
    check_counters("wrap");
    chk("R3", "blk_ovf set", int'(blk_ovf), 1);
    compute("wrap", 1'b0);

    // R10: events and a stray start while busy are dropped
    compute("noise", 1'b1);
    compute("noise_after", 1'b0);

    // R4 and sweep: pseudo-random rounds push the total past its wrap
    for (int r = 0; r < 14; r++) begin
      for (int k = 0; k < 10; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        erase(int'((seed >> 16) & 32'h7));
      end
      check_counters($sformatf("round%0d", r));
      compute($sformatf("round%0d", r), r[0]);
    end
    chk("R4", "tot_ovf final", int'(tot_ovf), 1);
    summary();
  end
endmodule